// File: doc/BRIEF.md
# Parity-Guarded SHA-1 Word Schedule Generator

This block produces the eighty 32-bit schedule words that feed the SHA-1 compression round, one word per clock. A host pulses `start`, then presents the sixteen words of a 512-bit message block on `word_in`. Each word comes with four byte-parity bits. The sixteen input words are passed straight through as W0 to W15. After the last of them, the block runs the rotate-XOR recurrence by itself for 64 further cycles, emitting W16 to W79, and then returns to idle.

Parity never leaves the data. Each stored word keeps its four parity bits in the same 16-deep shift register, and the 2:1 word multiplexer selects word and parity together. The XOR-rotate tree has a separate prediction path, which forms the output byte parities from the input byte parities and the byte-boundary bits that the rotate carries across. These predictions are compared against parity recomputed from the produced word. Input words are checked against their own parity as they arrive. All comparisons go through a two-rail checker. Its rails are latched onto a complementary output pair `err`/`err_n`, which stops being complementary when a fault is seen.

Top module: `sha1_sched_guard`

## Requirements
- R1: While loading, each cycle with `word_valid` high, starting with the cycle after an accepted `start`, accepts one word. It appears one cycle later on `w_out` with `w_par` equal to the `word_par_in` that came with it. The sixteen accepted words are W0 to W15 in arrival order.
- R2: Right after the sixteenth load, the block emits W16 to W79 on consecutive cycles. Each is W_t = rotate-left-by-one of (W_{t-3} XOR W_{t-8} XOR W_{t-14} XOR W_{t-16}).
- R3: For every computed word W16 to W79, when the loaded parities were correct, bit j of `w_par` equals the XOR of `w_out[8j+7:8j]` (even parity per byte, byte 0 in the low bits).
- R4: `w_valid` is high for exactly 80 cycles per block. Load cycles without `word_valid` add a gap and no output. After W79, `w_valid` stays low until the next block.
- R5: `start` has no effect while a block is in progress, and `word_valid` has no effect while idle.
- R6: After reset, and while no fault has been seen, `err` is 0 and `err_n` is 1.
- R7: If a loaded word disagrees with its parity in any byte (one data bit flipped, or one parity bit flipped), then `err` equals `err_n` from the cycle in which that word appears on `w_out`.
- R8: Once `err` equals `err_n`, it stays so until an accepted `start`. The pair then reads 0/1 on the following cycle.
- R9: `t_index` gives the schedule index t (0 to 79) of the word on `w_out` while `w_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a block when idle |
| word_in | input | 32 | Message word during loading |
| word_par_in | input | 4 | Even byte parity of `word_in`, bit j for byte j |
| word_valid | input | 1 | `word_in` holds a message word this cycle |
| w_out | output | 32 | Schedule word W_t |
| w_par | output | 4 | Byte parity carried with `w_out` |
| w_valid | output | 1 | `w_out` holds a schedule word |
| t_index | output | 7 | Index t of `w_out` |
| err | output | 1 | Error rail, 0 when fault-free |
| err_n | output | 1 | Complement rail, 1 when fault-free |

## Verification
The assertions assume the host drives a fresh `start` only while idle if it wants a block, and does not care about words offered outside a load phase. They also take the parity check on computed words to be meaningful only while the error pair is still complementary. This is because a corrupted load legitimately propagates wrong parity. The stimulus pulses `start` once per block and waits for the eightieth word before the next one. It also deliberately offers `start` during the compute phase and `word_valid` while idle, both of which should be ignored. A fault is injected only in dedicated blocks, and the parity comparison is suppressed for those blocks.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_RUN  = 2'd2
  } phase_t;

  // recurrence lags, fixed by the hash definition
  localparam int LAG_A = 3;
  localparam int LAG_B = 8;
  localparam int LAG_C = 14;
  localparam int LAG_D = 16;

endpackage

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ROUNDS = 80,
  parameter int IDX_W  = $clog2(ROUNDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             word_valid,
  output logic             step,
  output logic             load_sel,
  output logic             clr_err,
  output logic             busy,
  output logic [IDX_W-1:0] t_cnt
);

  localparam logic [IDX_W-1:0] LAST_LOAD = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] LAST_RUN  = IDX_W'(ROUNDS - 1);

  phase_t phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      t_cnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_LOAD;
            t_cnt <= '0;
          end
        end
        PH_LOAD: begin
          if (word_valid) begin
            t_cnt <= t_cnt + 1'b1;
            if (t_cnt == LAST_LOAD) phase <= PH_RUN;
          end
        end
        PH_RUN: begin
          t_cnt <= t_cnt + 1'b1;
          if (t_cnt == LAST_RUN) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    load_sel = (phase == PH_LOAD);
    step     = (load_sel && word_valid) || (phase == PH_RUN);
    clr_err  = (phase == PH_IDLE) && start;
    busy     = (phase != PH_IDLE);
  end

endmodule

// File: rtl/wsched_store.sv
module wsched_store #(
  parameter int WORD_W = 32,
  parameter int NBYTE  = 4,
  parameter int DEPTH  = 16,
  parameter int SLOT_A = 2,
  parameter int SLOT_B = 7,
  parameter int SLOT_C = 13,
  parameter int SLOT_D = 15
) (
  input  logic              clk,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] din,
  input  logic [NBYTE-1:0]  pin,
  output logic [WORD_W-1:0] wa,
  output logic [WORD_W-1:0] wb,
  output logic [WORD_W-1:0] wc,
  output logic [WORD_W-1:0] wd,
  output logic [NBYTE-1:0]  pa,
  output logic [NBYTE-1:0]  pb,
  output logic [NBYTE-1:0]  pc,
  output logic [NBYTE-1:0]  pd
);

  logic [WORD_W-1:0] word_q [DEPTH];
  logic [NBYTE-1:0]  par_q  [DEPTH];

  always_ff @(posedge clk) begin
    if (shift_en) begin
      word_q[0] <= din;
      par_q[0]  <= pin;
      for (int k = 1; k < DEPTH; k++) begin
        word_q[k] <= word_q[k-1];
        par_q[k]  <= par_q[k-1];
      end
    end
  end

  assign wa = word_q[SLOT_A];
  assign wb = word_q[SLOT_B];
  assign wc = word_q[SLOT_C];
  assign wd = word_q[SLOT_D];
  assign pa = par_q[SLOT_A];
  assign pb = par_q[SLOT_B];
  assign pc = par_q[SLOT_C];
  assign pd = par_q[SLOT_D];

endmodule

// File: rtl/wsched_tree.sv
module wsched_tree #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int NBYTE  = WORD_W / BYTE_W
) (
  input  logic [WORD_W-1:0] wa,
  input  logic [WORD_W-1:0] wb,
  input  logic [WORD_W-1:0] wc,
  input  logic [WORD_W-1:0] wd,
  input  logic [NBYTE-1:0]  pa,
  input  logic [NBYTE-1:0]  pb,
  input  logic [NBYTE-1:0]  pc,
  input  logic [NBYTE-1:0]  pd,
  output logic [WORD_W-1:0] y,
  output logic [NBYTE-1:0]  pred_par,
  output logic [NBYTE-1:0]  comp_par
);

  logic [WORD_W-1:0] mix;

  // datapath
  assign mix = wa ^ wb ^ wc ^ wd;
  assign y   = {mix[WORD_W-2:0], mix[WORD_W-1]};

  // prediction path: byte parities plus the two bits that cross each byte edge
  generate
    for (genvar j = 0; j < NBYTE; j++) begin : g_byte
      localparam int OUT_BIT = j * BYTE_W + BYTE_W - 1;
      localparam int IN_BIT  = (j * BYTE_W + WORD_W - 1) % WORD_W;
      logic leave_b, enter_b;
      assign leave_b = wa[OUT_BIT] ^ wb[OUT_BIT] ^ wc[OUT_BIT] ^ wd[OUT_BIT];
      assign enter_b = wa[IN_BIT] ^ wb[IN_BIT] ^ wc[IN_BIT] ^ wd[IN_BIT];
      assign pred_par[j] = pa[j] ^ pb[j] ^ pc[j] ^ pd[j] ^ leave_b ^ enter_b;
      assign comp_par[j] = ^y[j*BYTE_W +: BYTE_W];
    end
  endgenerate

endmodule

// File: rtl/wsched_trc.sv
module wsched_trc #(
  parameter int NPAIR = 4
) (
  input  logic [NPAIR-1:0] rail_a,
  input  logic [NPAIR-1:0] rail_b,
  output logic             z,
  output logic             z_n
);

  logic f, g, nf, ng;

  always_comb begin
    f = rail_a[0];
    g = rail_b[0];
    for (int i = 1; i < NPAIR; i++) begin
      nf = (f & rail_a[i]) | (g & rail_b[i]);
      ng = (f & rail_b[i]) | (g & rail_a[i]);
      f  = nf;
      g  = ng;
    end
    z   = f;
    z_n = g;
  end

endmodule

// File: rtl/sha1_sched_guard.sv
module sha1_sched_guard
  import wsched_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 16,
  parameter int ROUNDS = 80,
  parameter int NBYTE  = WORD_W / BYTE_W,
  parameter int IDX_W  = $clog2(ROUNDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word_in,
  input  logic [NBYTE-1:0]  word_par_in,
  input  logic              word_valid,
  output logic [WORD_W-1:0] w_out,
  output logic [NBYTE-1:0]  w_par,
  output logic              w_valid,
  output logic [IDX_W-1:0]  t_index,
  output logic              err,
  output logic              err_n
);

  localparam int SLOT_A = LAG_A - 1;
  localparam int SLOT_B = LAG_B - 1;
  localparam int SLOT_C = LAG_C - 1;
  localparam int SLOT_D = LAG_D - 1;

  logic             step, load_sel, clr_err, busy;
  logic [IDX_W-1:0] t_cnt;

  logic [WORD_W-1:0] tw_a, tw_b, tw_c, tw_d, tree_y;
  logic [NBYTE-1:0]  tp_a, tp_b, tp_c, tp_d, pred_par, comp_par;
  logic [WORD_W-1:0] nxt_word;
  logic [NBYTE-1:0]  nxt_par, in_comp, chk_a, chk_b;
  logic              rz, rz_n, fault;

  wsched_ctrl #(.DEPTH(DEPTH), .ROUNDS(ROUNDS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .word_valid(word_valid),
    .step(step), .load_sel(load_sel), .clr_err(clr_err), .busy(busy),
    .t_cnt(t_cnt)
  );

  wsched_store #(
    .WORD_W(WORD_W), .NBYTE(NBYTE), .DEPTH(DEPTH),
    .SLOT_A(SLOT_A), .SLOT_B(SLOT_B), .SLOT_C(SLOT_C), .SLOT_D(SLOT_D)
  ) u_store (
    .clk(clk), .shift_en(step), .din(nxt_word), .pin(nxt_par),
    .wa(tw_a), .wb(tw_b), .wc(tw_c), .wd(tw_d),
    .pa(tp_a), .pb(tp_b), .pc(tp_c), .pd(tp_d)
  );

  wsched_tree #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .NBYTE(NBYTE)) u_tree (
    .wa(tw_a), .wb(tw_b), .wc(tw_c), .wd(tw_d),
    .pa(tp_a), .pb(tp_b), .pc(tp_c), .pd(tp_d),
    .y(tree_y), .pred_par(pred_par), .comp_par(comp_par)
  );

  // parity recomputed on the incoming word
  generate
    for (genvar j = 0; j < NBYTE; j++) begin : g_inpar
      assign in_comp[j] = ^word_in[j*BYTE_W +: BYTE_W];
    end
  endgenerate

  // word multiplexer: message word while loading, recurrence otherwise
  always_comb begin
    nxt_word = load_sel ? word_in     : tree_y;
    nxt_par  = load_sel ? word_par_in : pred_par;
  end

  // check pairs: equal values become complementary rails
  always_comb begin
    if (!step) begin
      chk_a = '0;
      chk_b = '1;
    end else if (load_sel) begin
      chk_a = word_par_in;
      chk_b = ~in_comp;
    end else begin
      chk_a = pred_par;
      chk_b = ~comp_par;
    end
  end

  wsched_trc #(.NPAIR(NBYTE)) u_trc (
    .rail_a(chk_a), .rail_b(chk_b), .z(rz), .z_n(rz_n)
  );

  assign fault = (rz == rz_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      w_valid <= 1'b0;
      w_out   <= '0;
      w_par   <= '0;
      t_index <= '0;
      err     <= 1'b0;
      err_n   <= 1'b1;
    end else begin
      w_valid <= step;
      if (step) begin
        w_out   <= nxt_word;
        w_par   <= nxt_par;
        t_index <= t_cnt;
      end
      if (clr_err) begin
        err   <= 1'b0;
        err_n <= 1'b1;
      end else if ((err != err_n) && fault) begin
        err   <= rz;
        err_n <= rz_n;
      end
    end
  end

endmodule

// File: rtl/wsched_chk.sv
module wsched_chk #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 16,
  parameter int ROUNDS = 80,
  parameter int NBYTE  = WORD_W / BYTE_W,
  parameter int IDX_W  = $clog2(ROUNDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              w_valid,
  input logic [IDX_W-1:0]  t_index,
  input logic [WORD_W-1:0] w_out,
  input logic [NBYTE-1:0]  w_par,
  input logic              err,
  input logic              err_n
);

  logic [IDX_W-1:0] seen;
  logic [NBYTE-1:0] out_par;
  logic             accept;

  assign accept = start && !busy;

  generate
    for (genvar j = 0; j < NBYTE; j++) begin : g_op
      assign out_par[j] = ^w_out[j*BYTE_W +: BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          seen <= '0;
    else if (accept)  seen <= '0;
    else if (w_valid) seen <= seen + 1'b1;
  end

  AST_VALID_BUDGET: assert property (@(posedge clk) disable iff (rst)
    w_valid |-> (int'(seen) < ROUNDS)) else $error("budget");  // R4

  AST_INDEX_ORDER: assert property (@(posedge clk) disable iff (rst)
    w_valid |-> (t_index == seen)) else $error("index");  // R9

  AST_PARITY_CARRY: assert property (@(posedge clk) disable iff (rst)
    (w_valid && (err != err_n) && (int'(t_index) >= DEPTH)) |-> (w_par == out_par))
    else $error("parity");  // R3

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((err == err_n) && !accept) |=> (err == err_n)) else $error("hold");  // R8

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    accept |=> (!err && err_n)) else $error("clear");  // R8

endmodule

bind sha1_sched_guard wsched_chk #(
  .WORD_W(WORD_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH),
  .ROUNDS(ROUNDS), .NBYTE(NBYTE), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .w_valid(w_valid), .t_index(t_index), .w_out(w_out), .w_par(w_par),
  .err(err), .err_n(err_n)
);

// File: tb/sim_sha1_sched_guard.sv
module sim_sha1_sched_guard;

  localparam int CLK_P = 10;

  typedef struct packed {
    logic [6:0]  idx;
    logic [31:0] w;
    logic        chk;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] word_in = '0;
  logic [3:0]  word_par_in = '0;
  logic        word_valid = 1'b0;
  logic [31:0] w_out;
  logic [3:0]  w_par;
  logic        w_valid;
  logic [6:0]  t_index;
  logic        err, err_n;

  int   total = 0;
  int   bad = 0;
  int   nvalid = 0;
  int   cycles = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  sha1_sched_guard u0 (
    .clk(clk), .rst(rst), .start(start), .word_in(word_in),
    .word_par_in(word_par_in), .word_valid(word_valid),
    .w_out(w_out), .w_par(w_par), .w_valid(w_valid), .t_index(t_index),
    .err(err), .err_n(err_n)
  );

  function automatic logic [3:0] bpar(input logic [31:0] w);
    for (int j = 0; j < 4; j++) bpar[j] = ^w[j*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input string msg,
                       input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, msg, act, expv);
    end
  endtask

  // monitor: pops expected words as the design emits them
  always @(negedge clk) begin
    if (!rst && w_valid && !done) begin
      nvalid++;
      if (q.size() == 0) begin
        check(1'b0, "R5", "unexpected w_valid", 64'(w_out), 64'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(w_out == e.w, (e.idx < 16) ? "R1" : "R2", "word",
              64'(w_out), 64'(e.w));
        check(t_index == e.idx, "R9", "index", 64'(t_index), 64'(e.idx));
        if (e.chk)
          check(w_par == bpar(e.w), "R3", "parity", 64'(w_par), 64'(bpar(e.w)));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // kind: 0 clean, 1 parity bit flip, 2 data bit flip
  task automatic run_block(input logic [31:0] seed_blk[16], input int bad_idx,
                           input int kind, input bit gaps, input bit late_start);
    logic [31:0] wm[80];
    logic [31:0] x;
    logic [3:0]  p;
    int          fbit;
    fbit = 3 + bad_idx;
    for (int i = 0; i < 16; i++) wm[i] = seed_blk[i];
    if (kind == 2) wm[bad_idx][fbit] = ~wm[bad_idx][fbit];
    for (int t = 16; t < 80; t++) begin
      x = wm[t-3] ^ wm[t-8] ^ wm[t-14] ^ wm[t-16];
      wm[t] = {x[30:0], x[31]};
    end
    for (int t = 0; t < 80; t++) q.push_back('{7'(t), wm[t], (kind == 0)});
    nvalid = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!err && err_n, "R8", "pair after start", {62'd0, err, err_n}, 64'd1);
    for (int i = 0; i < 16; i++) begin
      if (gaps && (i % 5 == 2)) begin
        word_valid = 1'b0;
        @(negedge clk);
      end
      p = bpar(seed_blk[i]);
      if (kind == 1 && i == bad_idx) p[bad_idx % 4] = ~p[bad_idx % 4];
      word_in = wm[i];
      word_par_in = p;
      word_valid = 1'b1;
      @(negedge clk);
      if (kind != 0 && i == bad_idx)
        check(err == err_n, "R7", "fault flagged", {62'd0, err, err_n}, 64'd3);
    end
    word_valid = 1'b0;
    for (int c = 0; c < 64; c++) begin
      if (late_start && c == 20) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    repeat (3) @(negedge clk);
    check(nvalid == 80, "R4", "valid count", 64'(nvalid), 64'd80);
    check(w_valid == 1'b0, "R4", "idle after block", 64'(w_valid), 64'd0);
    check(q.size() == 0, "R2", "all words seen", 64'(q.size()), 64'd0);
    if (kind == 0)
      check(!err && err_n, "R6", "clean pair", {62'd0, err, err_n}, 64'd1);
    else
      check(err == err_n, "R8", "flag held", {62'd0, err, err_n}, 64'd3);
  endtask

  initial begin
    logic [31:0] blk[16];
    repeat (3) @(negedge clk);
    check(!w_valid && !err && err_n, "R6", "reset state",
          {61'd0, w_valid, err, err_n}, 64'd1);
    rst = 1'b0;
    @(negedge clk);

    // word_valid while idle must be ignored
    word_valid = 1'b1;
    word_in = 32'hdead_beef;
    word_par_in = bpar(32'hdead_beef);
    repeat (3) @(negedge clk);
    check(!w_valid, "R5", "idle word ignored", 64'(w_valid), 64'd0);
    word_valid = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 16; i++) blk[i] = '0;
    run_block(blk, 0, 0, 1'b0, 1'b0);

    for (int i = 0; i < 16; i++) blk[i] = 32'h0123_4567 * (i + 1) ^ 32'h8000_0001;
    run_block(blk, 0, 0, 1'b0, 1'b0);

    for (int n = 0; n < 3; n++) begin
      for (int i = 0; i < 16; i++) blk[i] = $urandom;
      run_block(blk, 0, 0, n == 1, n == 2);
    end

    for (int i = 0; i < 16; i++) blk[i] = $urandom;
    run_block(blk, 5, 1, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) blk[i] = $urandom;
    run_block(blk, 11, 2, 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) blk[i] = $urandom;
    run_block(blk, 0, 0, 1'b0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule